// File: doc/BRIEF.md
# Load-Use Interlock and Taken-Branch Flush Controller

This block is the hazard controller of a five-stage in-order pipeline in which branches and jumps are resolved in the decode stage. It watches the instruction held in the fetch/decode register and the instruction held in the decode/execute register. When a load in execute writes a register that the decode instruction reads, the controller freezes the program counter and the fetch/decode register for one cycle. In that same cycle it selects an all-zero control word into the decode/execute register. The load moves on, and in the next cycle its value reaches the waiting instruction through the forwarding paths.

When decode reports a taken branch or jump, the controller clears the fetch/decode register. The single instruction fetched behind the branch then becomes a no-op. A load-use stall always wins over a flush, because a branch that is waiting for an operand cannot resolve.

After reset is released, the controller keeps the front of the pipeline empty until the first clock edge. Each source field of the decode instruction comes with a flag that says whether the instruction actually reads it, so immediate fields that only look like register numbers never cause stalls.

Top module: `hzc_top`

## Requirements
- R1: While `rst_n` is low, and until the first rising clock edge after it goes high, the outputs are `pc_we`=0, `ifid_we`=0, `ifid_clr`=1 and `bubble_sel`=1.
- R2: A stall is raised when all of these hold: `idex_mem_rd`=1, `idex_dst` is nonzero, and `idex_dst` equals `ifid_rs` with `ifid_rs_used`=1, or equals `ifid_rt` with `ifid_rt_used`=1.
- R3: In a stall cycle, `pc_we`=0 and `ifid_we`=0.
- R4: In a stall cycle, `bubble_sel`=1, so the control word entering decode/execute is zeroed. In every other cycle after start-up, `bubble_sel`=0.
- R5: A load whose destination is register 0 never causes a stall.
- R6: A source field whose used flag is 0 never causes a stall, even when its value equals the load destination.
- R7: An instruction in decode/execute with `idex_mem_rd`=0 never causes a stall, whatever its destination.
- R8: A taken branch or jump (`br_taken`=1) with no stall gives `ifid_clr`=1, `pc_we`=1, `ifid_we`=1 and `bubble_sel`=0. Exactly one fetched instruction is discarded.
- R9: When a stall and `br_taken` occur in the same cycle, the stall outputs apply and `ifid_clr`=0.
- R10: With neither a stall nor a taken branch, the outputs are `pc_we`=1, `ifid_we`=1, `ifid_clr`=0 and `bubble_sel`=0.
- R11: When the pipeline feeds the bubble back into decode/execute, a load followed at once by a consumer stalls for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ifid_rs | input | REG_AW | First source register of the decode instruction |
| ifid_rs_used | input | 1 | Decode instruction reads `ifid_rs` |
| ifid_rt | input | REG_AW | Second source register of the decode instruction |
| ifid_rt_used | input | 1 | Decode instruction reads `ifid_rt` |
| idex_mem_rd | input | 1 | Instruction in decode/execute is a load |
| idex_dst | input | REG_AW | Destination register of the decode/execute instruction |
| br_taken | input | 1 | Branch or jump in decode is taken |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| ifid_clr | output | 1 | Fetch/decode register synchronous clear (turns it into a no-op) |
| bubble_sel | output | 1 | Select zero control word into decode/execute |

## Verification
The assertions assume that the surrounding pipeline honours the outputs. A frozen fetch/decode register must hold its source fields, a selected bubble must arrive in decode/execute as a non-load with destination 0, and `br_taken` must come only from the instruction that is actually in decode. The bench makes these assumptions true by building its inputs from its own model of the fetch, decode and execute registers. That model advances only as the required enables, clears and bubbles dictate. Random program sections draw register numbers from a small range so that matches, zero destinations and unused fields occur often.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

  // Control word the sequencer hands to the pipeline registers
  typedef struct packed {
    logic pc_we;
    logic ifid_we;
    logic ifid_clr;
    logic bubble;
  } hzc_ctl_t;

endpackage

// File: rtl/hzc_src_match.sv
module hzc_src_match #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic          src_used,
  input  logic [AW-1:0] dst,
  input  logic          dst_is_load,
  output logic          hit
);

  localparam logic [AW-1:0] ZERO_REG = '0;

  // One source field against the load destination
  always_comb begin
    hit = dst_is_load && src_used && (dst != ZERO_REG) && (src == dst);
  end

endmodule

// File: rtl/hzc_sequencer.sv
module hzc_sequencer
  import hzc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     stall_req,
  input  logic     taken_req,
  output hzc_ctl_t ctl
);

  logic live_q;
  logic live_d;
  logic live_en;

  // Start-up flag: becomes set on the first edge after reset release
  always_comb begin
    live_en = !live_q;
    live_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
    end else if (live_en) begin
      live_q <= live_d;
    end
  end

  // Priority: start-up hold, then stall, then flush, then run
  always_comb begin
    ctl = '{pc_we: 1'b1, ifid_we: 1'b1, ifid_clr: 1'b0, bubble: 1'b0};
    if (!live_q) begin
      ctl = '{pc_we: 1'b0, ifid_we: 1'b0, ifid_clr: 1'b1, bubble: 1'b1};
    end else if (stall_req) begin
      ctl = '{pc_we: 1'b0, ifid_we: 1'b0, ifid_clr: 1'b0, bubble: 1'b1};
    end else if (taken_req) begin
      ctl = '{pc_we: 1'b1, ifid_we: 1'b1, ifid_clr: 1'b1, bubble: 1'b0};
    end
  end

  // R9
  stall_beats_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && stall_req && taken_req) |-> !ctl.ifid_clr);

  // R8
  taken_flushes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && taken_req && !stall_req) |-> (ctl.ifid_clr && ctl.pc_we && !ctl.bubble));

  // R1
  startup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !live_q |-> (!ctl.pc_we && ctl.ifid_clr));

endmodule

// File: rtl/hzc_top.sv
module hzc_top
  import hzc_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] ifid_rs,
  input  logic              ifid_rs_used,
  input  logic [REG_AW-1:0] ifid_rt,
  input  logic              ifid_rt_used,
  input  logic              idex_mem_rd,
  input  logic [REG_AW-1:0] idex_dst,
  input  logic              br_taken,
  output logic              pc_we,
  output logic              ifid_we,
  output logic              ifid_clr,
  output logic              bubble_sel
);

  localparam int NSRC = 2;

  logic [NSRC-1:0][REG_AW-1:0] src_vec;
  logic [NSRC-1:0]             used_vec;
  logic [NSRC-1:0]             hit_vec;
  logic                        stall;
  hzc_ctl_t                    ctl;

  always_comb begin
    src_vec[0]  = ifid_rs;
    src_vec[1]  = ifid_rt;
    used_vec[0] = ifid_rs_used;
    used_vec[1] = ifid_rt_used;
  end

  // One comparator per source field of the decode instruction
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hzc_src_match #(.AW(REG_AW)) u_match (
      .src         (src_vec[g]),
      .src_used    (used_vec[g]),
      .dst         (idex_dst),
      .dst_is_load (idex_mem_rd),
      .hit         (hit_vec[g])
    );
  end

  always_comb begin
    stall = |hit_vec;
  end

  hzc_sequencer u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall_req (stall),
    .taken_req (br_taken),
    .ctl       (ctl)
  );

  always_comb begin
    pc_we      = ctl.pc_we;
    ifid_we    = ctl.ifid_we;
    ifid_clr   = ctl.ifid_clr;
    bubble_sel = ctl.bubble;
  end

  // R3
  bubble_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_sel |-> (!pc_we && !ifid_we));

  // R2
  stall_gives_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (bubble_sel && !ifid_clr));

  // R5
  zero_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_dst == '0) |-> !stall);

  // R6
  unused_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ifid_rs_used && !ifid_rt_used) |-> !stall);

  // R7
  non_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idex_mem_rd |-> !stall);

endmodule

// File: tb/hzc_top_tb.sv
module hzc_top_tb;

  localparam int AW    = 5;
  localparam int PLEN  = 64;
  localparam int K_ALU = 0;
  localparam int K_LD  = 1;
  localparam int K_ST  = 2;
  localparam int K_BT  = 3;
  localparam int K_BN  = 4;
  localparam int K_J   = 5;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] ifid_rs;
  logic          ifid_rs_used;
  logic [AW-1:0] ifid_rt;
  logic          ifid_rt_used;
  logic          idex_mem_rd;
  logic [AW-1:0] idex_dst;
  logic          br_taken;
  logic          pc_we;
  logic          ifid_we;
  logic          ifid_clr;
  logic          bubble_sel;

  hzc_top #(.REG_AW(AW)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ifid_rs      (ifid_rs),
    .ifid_rs_used (ifid_rs_used),
    .ifid_rt      (ifid_rt),
    .ifid_rt_used (ifid_rt_used),
    .idex_mem_rd  (idex_mem_rd),
    .idex_dst     (idex_dst),
    .br_taken     (br_taken),
    .pc_we        (pc_we),
    .ifid_we      (ifid_we),
    .ifid_clr     (ifid_clr),
    .bubble_sel   (bubble_sel)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  // Program store
  int       p_kind [PLEN];
  int       p_dst  [PLEN];
  int       p_rs   [PLEN];
  int       p_rt   [PLEN];
  bit       p_rsu  [PLEN];
  bit       p_rtu  [PLEN];

  // Pipeline register model
  int pc_m;
  int ifid_m;      // -1 = no-op
  bit idex_ld_m;
  int idex_dst_m;
  bit live_m;
  bit prev_stall;

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic put(input int i, input int k, input int d, input int rs, input bit rsu,
                     input int rt, input bit rtu);
    p_kind[i] = k; p_dst[i] = d; p_rs[i] = rs; p_rsu[i] = rsu; p_rt[i] = rt; p_rtu[i] = rtu;
  endtask

  task automatic build_program();
    put(0,  K_LD,  3,  1, 1, 0, 0);
    put(1,  K_ALU, 4,  3, 1, 2, 1);   // rs use of load: stall
    put(2,  K_LD,  4,  1, 1, 0, 0);
    put(3,  K_ALU, 5,  2, 1, 4, 1);   // rt use: stall
    put(4,  K_LD,  0,  1, 1, 0, 0);
    put(5,  K_ALU, 6,  0, 1, 0, 1);   // zero destination: no stall
    put(6,  K_LD,  6,  2, 1, 0, 0);
    put(7,  K_ALU, 7,  6, 0, 6, 0);   // fields match but unused
    put(8,  K_ALU, 8,  1, 1, 0, 0);
    put(9,  K_ALU, 9,  8, 1, 8, 1);   // non-load producer
    put(10, K_BT,  0,  9, 1, 9, 1);   // taken: flush 11
    put(11, K_ALU, 10, 1, 1, 1, 1);
    put(12, K_LD,  11, 1, 1, 0, 0);
    put(13, K_BT,  0, 11, 1, 2, 1);   // stall and taken together
    put(14, K_ALU, 12, 1, 1, 0, 0);
    put(15, K_J,   0,  0, 0, 0, 0);
    put(16, K_ALU, 13, 1, 1, 0, 0);
    put(17, K_BN,  0,  1, 1, 2, 1);
    put(18, K_LD,  12, 3, 1, 0, 0);
    put(19, K_ST,  0,  5, 1, 12, 1);  // store data from load: stall
    put(20, K_LD,  13, 1, 1, 0, 0);
    put(21, K_ALU, 1,  2, 1, 0, 0);
    put(22, K_ALU, 2, 13, 1, 0, 0);   // second next: no stall
    for (int i = 23; i < PLEN; i++) begin
      put(i, int'($urandom % 6), int'($urandom % 4), int'($urandom % 4), bit'($urandom % 2),
          int'($urandom % 4), bit'($urandom % 2));
      if (p_kind[i] == K_ST || p_kind[i] == K_BT || p_kind[i] == K_BN || p_kind[i] == K_J)
        p_dst[i] = 0;
      if (p_kind[i] == K_J) begin
        p_rsu[i] = 0; p_rtu[i] = 0;
      end
    end
  endtask

  // Drive DUT inputs from the model registers
  task automatic drive_from_model();
    if (ifid_m >= 0) begin
      ifid_rs      = AW'(p_rs[ifid_m]);
      ifid_rs_used = p_rsu[ifid_m];
      ifid_rt      = AW'(p_rt[ifid_m]);
      ifid_rt_used = p_rtu[ifid_m];
      br_taken     = (p_kind[ifid_m] == K_BT) || (p_kind[ifid_m] == K_J);
    end else begin
      ifid_rs = '0; ifid_rs_used = 0; ifid_rt = '0; ifid_rt_used = 0; br_taken = 0;
    end
    idex_mem_rd = idex_ld_m;
    idex_dst    = AW'(idex_dst_m);
  endtask

  initial begin
    rst_n = 1'b0;
    ifid_rs = 5'd7; ifid_rs_used = 1; ifid_rt = 5'd7; ifid_rt_used = 1;
    idex_mem_rd = 1; idex_dst = 5'd7; br_taken = 1;
    pc_m = 0; ifid_m = -1; idex_ld_m = 0; idex_dst_m = 0; live_m = 0; prev_stall = 0;
    build_program();

    // R1: held in reset even though inputs request a stall and a flush
    repeat (2) @(negedge clk);
    #5;
    chk(pc_we, 1'b0, "R1", "pc_we in reset");
    chk(ifid_we, 1'b0, "R1", "ifid_we in reset");
    chk(ifid_clr, 1'b1, "R1", "ifid_clr in reset");
    chk(bubble_sel, 1'b1, "R1", "bubble_sel in reset");
    @(negedge clk);
    rst_n = 1'b1;
    drive_from_model();
    #5;
    chk(pc_we, 1'b0, "R1", "pc_we before first edge");
    chk(ifid_clr, 1'b1, "R1", "ifid_clr before first edge");
    @(posedge clk);
    live_m = 1;

    for (int cyc = 0; cyc < 160; cyc++) begin
      @(negedge clk);
      drive_from_model();
      #5;
      begin
        bit hit_rs, hit_rt, stall, taken;
        hit_rs = idex_ld_m && idex_dst_m != 0 && ifid_m >= 0 && p_rsu[ifid_m] && p_rs[ifid_m] == idex_dst_m;
        hit_rt = idex_ld_m && idex_dst_m != 0 && ifid_m >= 0 && p_rtu[ifid_m] && p_rt[ifid_m] == idex_dst_m;
        stall  = hit_rs || hit_rt;
        taken  = br_taken;
        if (stall && taken) begin
          chk(pc_we, 1'b0, "R9", "pc_we stall+taken");
          chk(ifid_we, 1'b0, "R9", "ifid_we stall+taken");
          chk(ifid_clr, 1'b0, "R9", "ifid_clr stall+taken");
          chk(bubble_sel, 1'b1, "R9", "bubble_sel stall+taken");
        end else if (stall) begin
          chk(pc_we, 1'b0, "R2", "pc_we on load-use");
          chk(ifid_we, 1'b0, "R3", "ifid_we on load-use");
          chk(ifid_clr, 1'b0, "R3", "ifid_clr on load-use");
          chk(bubble_sel, 1'b1, "R4", "bubble_sel on load-use");
        end else begin
          string tg;
          if (idex_ld_m && idex_dst_m == 0 && ifid_m >= 0 &&
              ((p_rsu[ifid_m] && p_rs[ifid_m] == 0) || (p_rtu[ifid_m] && p_rt[ifid_m] == 0)))
            tg = "R5";
          else if (idex_ld_m && ifid_m >= 0 &&
              ((!p_rsu[ifid_m] && p_rs[ifid_m] == idex_dst_m) || (!p_rtu[ifid_m] && p_rt[ifid_m] == idex_dst_m)))
            tg = "R6";
          else if (!idex_ld_m && idex_dst_m != 0)
            tg = "R7";
          else if (taken)
            tg = "R8";
          else
            tg = "R10";
          chk(pc_we, 1'b1, tg, "pc_we no stall");
          chk(ifid_we, 1'b1, tg, "ifid_we no stall");
          chk(ifid_clr, taken ? 1'b1 : 1'b0, taken ? "R8" : tg, "ifid_clr no stall");
          chk(bubble_sel, 1'b0, "R4", "bubble_sel no stall");
        end
        // R11: the bubble fed back ends the stall after one cycle
        if (prev_stall) chk(bubble_sel, 1'b0, "R11", "second consecutive stall");
        prev_stall = stall;

        @(posedge clk);
        if (stall) begin
          idex_ld_m = 0; idex_dst_m = 0;
        end else begin
          if (ifid_m >= 0) begin
            idex_ld_m  = (p_kind[ifid_m] == K_LD);
            idex_dst_m = p_dst[ifid_m];
          end else begin
            idex_ld_m = 0; idex_dst_m = 0;
          end
          if (taken) ifid_m = -1;
          else       ifid_m = (pc_m < PLEN) ? pc_m : -1;
          if (pc_m < PLEN) pc_m++;
        end
      end
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule